// File: doc/BRIEF.md
# Octave-Range Divider Tap Selector

This block divides a fast sampling clock through a free-running binary counter and picks two taps from it. The first tap is the detection-frequency square wave. The second is the reference-frequency square wave. The tap is chosen from a 4-bit octave number and a second-harmonic flag. The supported octaves are 2 to 14, and each step up doubles the output rate. Octave 14 gives the fastest tap, which toggles on every clock edge.

In normal mode the reference runs at the detection rate. In second-harmonic mode it comes from the next slower stage, so it runs at half the detection rate. The reference is retimed by a register that loads only on edges of the tap one stage faster than the reference, which is twice its rate. The block drives two registered copies of the retimed signal, one for a loop circuit and one for an external output.

When the setting changes, both outputs are blanked. They stay blanked for at least one full period of the new reference tap, and they are released at phase zero of the chain, so no shortened pulse appears. A code outside the octave range holds every output low and raises an error flag.

Top module: `octave_tap_sel`

## Requirements
- R1: `range_i` is an unsigned binary octave number with bit 3 as the MSB. Only the values 2 to 14 are valid. At most one bank of the tap multiplexer is gated on at a time.
- R2: For a valid octave r, `det_o` is a square wave with a period of 2^(15-r) clock cycles. It is high for exactly half of each period.
- R3: With `harm_i`=0, the reference copies have the same period as `det_o`, with a 50 % duty cycle. Each rising edge of a reference copy comes exactly one cycle after a rising edge of `det_o`.
- R4: With `harm_i`=1, the reference copies have twice the period of `det_o`, with a 50 % duty cycle. Each rising edge of a reference copy comes exactly one cycle after a falling edge of `det_o`.
- R5: One cycle after an invalid code is applied, `err_o` is 1 and all three outputs are 0. This holds for as long as the code stays invalid.
- R6: After any change of `range_i` or `harm_i`, all outputs are 0 from the next cycle on. `det_o` then stays low for at least one full period of the new reference tap. The first pulses after release have full width.
- R7: `ref_loop_o` and `ref_out_o` are equal on every cycle.
- R8: Reset is synchronous and active high. It clears the divider chain. At the first clock edge with `rst` high, all outputs and `err_o` go to 0, and the setting returns to octave 14 in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock that feeds the divider chain |
| rst | input | 1 | Synchronous active-high reset |
| range_i | input | 4 | Octave number, valid values 2 to 14 |
| harm_i | input | 1 | Second-harmonic mode: reference one octave below detection |
| det_o | output | 1 | Detection-frequency tap |
| ref_loop_o | output | 1 | Retimed reference, copy for the loop circuit |
| ref_out_o | output | 1 | Retimed reference, copy for the external output |
| err_o | output | 1 | High while the applied octave code is invalid |

## Verification
The hardest behaviour to reach from the ports is the release after a change. The blanking has to end exactly at a phase-zero wrap of the new reference tap. This must hold whatever phase the chain was in when the inputs moved, and also for the slowest setting, whose window is tens of thousands of cycles long. The stimulus applies every octave in both modes back to back. Each setting takes over at whatever phase the previous measurement left the counter in. For every setting, the bench measures the blanking length, the first full period and the first high phase. It then drives invalid codes from a running state and applies a reset while the code is still invalid.

// File: rtl/octave_tap_pkg.sv
`timescale 1ns/1ps
package octave_tap_pkg;
    // Each bank of the tap multiplexer picks one of 2**SUB_W taps.
    localparam int SUB_W   = 3;
    localparam int BANK_SZ = 1 << SUB_W;

    // Select field for one bank: a 3-bit tap number plus a gate bit.
    typedef struct packed {
        logic             gate;
        logic [SUB_W-1:0] sub;
    } tap_fld_t;
endpackage

// File: rtl/octave_tap_chain.sv
`timescale 1ns/1ps
module octave_tap_chain #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } chain_st_t;

    chain_st_t st_d, st_q;

    // Bit k of the counter is the divide-by-2^(k+1) stage.
    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/octave_tap_decode.sv
`timescale 1ns/1ps
module octave_tap_decode
    import octave_tap_pkg::*;
#(
    parameter int RANGE_W   = 4,
    parameter int MIN_RANGE = 2,
    parameter int MAX_RANGE = 14,
    parameter int IDX_W     = 4,
    parameter int NBANK     = 2
) (
    input  logic [RANGE_W-1:0]   range_i,
    input  logic                 harm_i,
    output logic                 valid_o,
    output logic [IDX_W-1:0]     ref_idx_o,
    output tap_fld_t [NBANK-1:0] det_fld_o,
    output tap_fld_t [NBANK-1:0] ref_fld_o
);
    int rng;
    int didx;
    int ridx;

    always_comb begin
        rng     = int'(range_i);
        valid_o = (rng >= MIN_RANGE) && (rng <= MAX_RANGE);
        // The top octave uses stage 0; each octave lower moves one stage down.
        didx    = valid_o ? (MAX_RANGE - rng) : 0;
        ridx    = valid_o ? (didx + int'(harm_i)) : 0;
        ref_idx_o = IDX_W'(ridx);
        for (int b = 0; b < NBANK; b++) begin
            det_fld_o[b].gate = valid_o && ((didx / BANK_SZ) == b);
            det_fld_o[b].sub  = SUB_W'(didx % BANK_SZ);
            ref_fld_o[b].gate = valid_o && ((ridx / BANK_SZ) == b);
            ref_fld_o[b].sub  = SUB_W'(ridx % BANK_SZ);
        end
    end
endmodule

// File: rtl/octave_tap_mux.sv
`timescale 1ns/1ps
module octave_tap_mux
    import octave_tap_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int NBANK = 2
) (
    input  logic [CNT_W-1:0]     taps_i,
    input  tap_fld_t [NBANK-1:0] fld_i,
    output logic                 tap_o
);
    localparam int PAD_W = NBANK * BANK_SZ;

    logic [PAD_W-1:0] padded;
    logic [NBANK-1:0] bank_out;

    assign padded = PAD_W'(taps_i);

    // Cascade: each gated bank picks one tap, then the bank outputs are ORed.
    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic [BANK_SZ-1:0] grp;
            assign grp         = padded[b*BANK_SZ +: BANK_SZ];
            assign bank_out[b] = fld_i[b].gate & grp[fld_i[b].sub];
        end
    endgenerate

    assign tap_o = |bank_out;
endmodule

// File: rtl/octave_tap_sel.sv
`timescale 1ns/1ps
module octave_tap_sel
    import octave_tap_pkg::*;
#(
    parameter int RANGE_W   = 4,
    parameter int MIN_RANGE = 2,
    parameter int MAX_RANGE = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RANGE_W-1:0] range_i,
    input  logic               harm_i,
    output logic               det_o,
    output logic               ref_loop_o,
    output logic               ref_out_o,
    output logic               err_o
);
    localparam int CNT_W = MAX_RANGE - MIN_RANGE + 2;
    localparam int IDX_W = $clog2(CNT_W);
    localparam int NBANK = (CNT_W + BANK_SZ - 1) / BANK_SZ;

    typedef struct packed {
        logic [RANGE_W-1:0] rng;
        logic               harm;
        logic               en;
        logic               wrap_seen;
        logic               ref_a;
        logic               ref_b;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [CNT_W-1:0]     cnt;
    logic                 valid;
    logic [IDX_W-1:0]     ref_idx;
    tap_fld_t [NBANK-1:0] det_fld;
    tap_fld_t [NBANK-1:0] ref_fld;
    logic                 det_tap;
    logic                 ref_tap;
    logic                 cfg_chg;
    logic                 wrap;
    logic                 strobe;
    logic                 ref_raw;

    octave_tap_chain #(.CNT_W(CNT_W)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt)
    );

    octave_tap_decode #(
        .RANGE_W   (RANGE_W),
        .MIN_RANGE (MIN_RANGE),
        .MAX_RANGE (MAX_RANGE),
        .IDX_W     (IDX_W),
        .NBANK     (NBANK)
    ) u_decode (
        .range_i   (st_q.rng),
        .harm_i    (st_q.harm),
        .valid_o   (valid),
        .ref_idx_o (ref_idx),
        .det_fld_o (det_fld),
        .ref_fld_o (ref_fld)
    );

    octave_tap_mux #(.CNT_W(CNT_W), .NBANK(NBANK)) u_det_mux (
        .taps_i (cnt),
        .fld_i  (det_fld),
        .tap_o  (det_tap)
    );

    octave_tap_mux #(.CNT_W(CNT_W), .NBANK(NBANK)) u_ref_mux (
        .taps_i (cnt),
        .fld_i  (ref_fld),
        .tap_o  (ref_tap)
    );

    always_comb begin
        cfg_chg = (range_i != st_q.rng) || (harm_i != st_q.harm);
        // wrap: reference stage and every faster stage are at their last count.
        // strobe: the stage one faster than the reference has just wrapped.
        wrap    = 1'b1;
        strobe  = 1'b1;
        for (int k = 0; k < CNT_W; k++) begin
            if (k <= int'(ref_idx)) wrap   = wrap & cnt[k];
            if (k <  int'(ref_idx)) strobe = strobe & ~cnt[k];
        end
        ref_raw = st_q.en & ref_tap;

        st_d = st_q;
        if (cfg_chg) begin
            st_d.rng       = range_i;
            st_d.harm      = harm_i;
            st_d.en        = 1'b0;
            st_d.wrap_seen = 1'b0;
        end else if (!valid) begin
            st_d.en        = 1'b0;
            st_d.wrap_seen = 1'b0;
        end else if (!st_q.en && wrap) begin
            // The first wrap ends a partial period; the second ends a full one.
            if (st_q.wrap_seen) st_d.en        = 1'b1;
            else                st_d.wrap_seen = 1'b1;
        end

        if (!st_d.en) begin
            st_d.ref_a = 1'b0;
            st_d.ref_b = 1'b0;
        end else if (strobe) begin
            st_d.ref_a = ref_raw;
            st_d.ref_b = ref_raw;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.rng       <= RANGE_W'(MAX_RANGE);
            st_q.harm      <= 1'b0;
            st_q.en        <= 1'b0;
            st_q.wrap_seen <= 1'b0;
            st_q.ref_a     <= 1'b0;
            st_q.ref_b     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign det_o      = st_q.en & det_tap;
    assign ref_loop_o = st_q.ref_a;
    assign ref_out_o  = st_q.ref_b;
    assign err_o      = ~valid;

    logic [NBANK-1:0] det_gates;
    always_comb begin
        for (int b = 0; b < NBANK; b++) det_gates[b] = det_fld[b].gate;
    end

    p_one_bank_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(det_gates));

    p_err_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (!det_o && !ref_loop_o && !ref_out_o));

    p_blank_on_change_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_chg |=> (!det_o && !ref_loop_o && !ref_out_o));

    p_phase_norm_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(ref_loop_o) && !st_q.harm) |-> ($past(det_o) && !$past(det_o, 2)));

    p_phase_harm_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(ref_loop_o) && st_q.harm) |-> (!$past(det_o) && $past(det_o, 2)));

    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |=> (!det_o && !ref_loop_o && !ref_out_o && !err_o));
endmodule

// File: tb/octave_tap_sel_bench.sv
`timescale 1ns/1ps
module octave_tap_sel_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] range_i = 4'd14;
    logic       harm_i = 1'b0;
    logic       det_o, ref_loop_o, ref_out_o, err_o;

    always #2.5 clk = ~clk;

    octave_tap_sel u_octave_tap_sel (
        .clk        (clk),
        .rst        (rst),
        .range_i    (range_i),
        .harm_i     (harm_i),
        .det_o      (det_o),
        .ref_loop_o (ref_loop_o),
        .ref_out_o  (ref_out_o),
        .err_o      (err_o)
    );

    typedef struct {
        string tag;
        int    val;
    } item_t;

    item_t exp_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    go = 1'b0;
    bit    ended = 1'b0;
    int    cur_pr = 0;
    bit    cur_h = 1'b0;

    task automatic check(input string tag, input int act, input int expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Driver: apply a setting and queue what the requirements predict.
    task automatic run_cfg(input int r, input bit h);
        int pd;
        int pr;
        item_t it;
        @(negedge clk);
        range_i = 4'(r);
        harm_i  = h;
        pd = 1 << (15 - r);
        pr = h ? 2 * pd : pd;
        cur_pr = pr;
        cur_h  = h;
        it.tag = $sformatf("R2 det period r%0d h%0d", r, h);     it.val = pd;     exp_q.push_back(it);
        it.tag = $sformatf("R2 det high r%0d h%0d", r, h);       it.val = pd / 2; exp_q.push_back(it);
        it.tag = $sformatf("R3/R4 ref period r%0d h%0d", r, h);  it.val = pr;     exp_q.push_back(it);
        it.tag = $sformatf("R3/R4 ref high r%0d h%0d", r, h);    it.val = pr / 2; exp_q.push_back(it);
        it.tag = $sformatf("R6 blanking r%0d h%0d", r, h);       it.val = 1;      exp_q.push_back(it);
        it.tag = $sformatf("R3/R4 ref phase r%0d h%0d", r, h);   it.val = 1;      exp_q.push_back(it);
        it.tag = $sformatf("R7 copy mismatches r%0d h%0d", r, h); it.val = 0;     exp_q.push_back(it);
        go = 1'b1;
        wait (!go);
    endtask

    // Monitor: measure edges at the ports and compare with the queue.
    initial begin
        forever begin
            int n;
            int dr1, dr2, df1, rr1, rr2, rf1, cmis;
            bit early_ok;
            logic pd_q, pr_q;
            int act[7];
            item_t it;
            wait (go);
            n = 0; dr1 = -1; dr2 = -1; df1 = -1; rr1 = -1; rr2 = -1; rf1 = -1;
            cmis = 0; early_ok = 1'b1; pd_q = 1'b0; pr_q = 1'b0;
            while (dr2 < 0 || rr2 < 0 || rf1 < 0) begin
                @(negedge clk);
                n++;
                if (ref_loop_o !== ref_out_o) cmis++;
                if (n == 1 && (det_o !== 1'b0 || ref_loop_o !== 1'b0 || ref_out_o !== 1'b0))
                    early_ok = 1'b0;
                if (det_o && !pd_q) begin
                    if (dr1 < 0) dr1 = n;
                    else if (dr2 < 0) dr2 = n;
                end
                if (!det_o && pd_q && dr1 >= 0 && df1 < 0) df1 = n;
                if (ref_loop_o && !pr_q) begin
                    if (rr1 < 0) rr1 = n;
                    else if (rr2 < 0) rr2 = n;
                end
                if (!ref_loop_o && pr_q && rr1 >= 0 && rf1 < 0) rf1 = n;
                pd_q = det_o;
                pr_q = ref_loop_o;
            end
            act[0] = dr2 - dr1;
            act[1] = df1 - dr1;
            act[2] = rr2 - rr1;
            act[3] = rf1 - rr1;
            act[4] = (early_ok && (dr1 - 1 >= cur_pr)) ? 1 : 0;
            act[5] = cur_h ? (rr1 - df1) : (rr1 - dr1);
            act[6] = cmis;
            for (int i = 0; i < 7; i++) begin
                it = exp_q.pop_front();
                check(it.tag, act[i], it.val);
            end
            go = 1'b0;
        end
    end

    // R5 / R1: a code outside 2..14 silences the block and flags an error.
    task automatic inv_code(input int c);
        int bad;
        @(negedge clk);
        range_i = 4'(c);
        @(negedge clk);
        check($sformatf("R5 err raised code %0d", c), int'(err_o), 1);
        check($sformatf("R5 outputs low code %0d", c),
              int'({det_o, ref_loop_o, ref_out_o}), 0);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (det_o || ref_loop_o || ref_out_o || !err_o) bad++;
        end
        check($sformatf("R1 code %0d held invalid", c), bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 det low in reset", int'(det_o), 0);
        check("R8 ref copies low in reset", int'({ref_loop_o, ref_out_o}), 0);
        check("R8 err low in reset", int'(err_o), 0);
        rst = 1'b0;

        for (int r = 14; r >= 2; r--) run_cfg(r, 1'b0);
        inv_code(0);
        inv_code(1);
        for (int r = 14; r >= 2; r--) run_cfg(r, 1'b1);
        inv_code(15);

        // Reset while the code is still invalid.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 err cleared by reset", int'(err_o), 0);
        check("R8 outputs low after reset", int'({det_o, ref_loop_o, ref_out_o}), 0);
        rst = 1'b0;
        run_cfg(5, 1'b0);

        finish_run();
    end

    initial begin
        repeat (198000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule